// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits behind a host I/O port interface. It turns the standard two-port configuration method into configuration cycles. A dword write to the address port loads a selector register that names a bus, device, function and 32-bit register. The data port then acts as a window onto that register. Each access to the window is decoded against the selector and steered to one of two places: the on-chip configuration register file, through a one-cycle register port, or a downstream request port. Downstream requests are tagged as plain I/O, Type 0 configuration or Type 1 configuration.

Bus 0 traffic stays on chip only when the addressed device is one of the first `NUM_INT_DEV` device numbers and that device is enabled. Device 0, the host bridge, is always enabled. Traffic to any other device on bus 0 goes downstream as Type 0, and traffic to any nonzero bus goes downstream as Type 1. Host accesses that are not configuration accesses are forwarded as plain I/O. The block handles one host transaction at a time.

The host request, host response, downstream request and downstream response channels are all valid/ready. A transfer happens on a clock edge where both valid and ready are high. The block holds its valid and payload steady while the receiver keeps ready low. The host must hold its request payload steady until the request is accepted.

Top module: `cfg_access_xlat`

## Requirements
- R1: A write to port 0CF8h with byte enables 1111 loads the selector from data bits 31 and 23:2. A dword read of 0CF8h returns the selector with bits 30:24 and 1:0 as zero.
- R2: After reset the selector is zero, `hreq_ready` is 1, and `hrsp_valid`, `dreq_valid` and `ireg_en` are 0.
- R3: A window access (ports 0CFCh to 0CFFh) while selector bit 31 is clear is forwarded downstream with kind 0 (plain I/O) and the full 16-bit port as address. The same applies to a non-dword access to 0CF8h, which leaves the selector unchanged, and to any other port.
- R4: A window access to bus 0 at an enabled internal device (device number below `NUM_INT_DEV`) raises `ireg_en` for exactly one cycle, in the accept cycle. It presents the device, function and register index from the selector, and it sends nothing downstream. A read returns the `ireg_rdata` value sampled in that cycle.
- R5: Device 0 on bus 0 is always handled internally, whatever `dev_en` holds. `dev_en[i]` enables device i+1.
- R6: A bus 0 window access to a disabled internal device, or to any device number at or above `NUM_INT_DEV`, goes downstream with kind 1 (Type 0).
- R7: A window access to a nonzero bus goes downstream with kind 2 (Type 1). The configuration address is laid out as bits 31:24 zero, bus in 23:16, device in 15:11, function in 10:8, register index in 7:2 and bits 1:0 zero.
- R8: The host byte enables, write flag and write data of a window access reach the selected target unchanged.
- R9: A read whose downstream response has `drsp_claimed` low returns all ones. Every write returns a zero response word.
- R10: Each channel holds valid and payload stable under back-pressure. A new host request is accepted only when no earlier transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Host request ready |
| hreq_write | input | 1 | Host request is a write |
| hreq_port | input | 16 | Host I/O port address |
| hreq_be | input | 4 | Host byte enables |
| hreq_wdata | input | 32 | Host write data |
| hrsp_valid | output | 1 | Host response valid |
| hrsp_ready | input | 1 | Host response ready |
| hrsp_rdata | output | 32 | Host response data |
| dev_en | input | NUM_INT_DEV-1 | Enables for internal devices 1 and up |
| ireg_en | output | 1 | Internal register access strobe |
| ireg_write | output | 1 | Internal access is a write |
| ireg_dev | output | 5 | Internal device number |
| ireg_fn | output | 3 | Internal function number |
| ireg_reg | output | 6 | Internal 32-bit register index |
| ireg_be | output | 4 | Internal byte enables |
| ireg_wdata | output | 32 | Internal write data |
| ireg_rdata | input | 32 | Internal read data, same cycle |
| dreq_valid | output | 1 | Downstream request valid |
| dreq_ready | input | 1 | Downstream request ready |
| dreq_kind | output | 2 | 0 plain I/O, 1 Type 0, 2 Type 1 |
| dreq_write | output | 1 | Downstream request is a write |
| dreq_addr | output | 32 | I/O port or configuration address |
| dreq_be | output | 4 | Downstream byte enables |
| dreq_wdata | output | 32 | Downstream write data |
| drsp_valid | input | 1 | Downstream response valid |
| drsp_ready | output | 1 | Downstream response ready |
| drsp_claimed | input | 1 | A target claimed the request |
| drsp_rdata | input | 32 | Downstream read data |

## Verification
The assertions assume that the host and the downstream side keep to the handshake rules. A request payload stays fixed until it is accepted. Exactly one downstream response follows each accepted downstream request. The internal register port returns its data in the same cycle as `ireg_en`. The bench's host and responder drive their channels only on falling edges and change a payload only after the handshake that consumes it. The stall counts vary across accesses, and every request gets a response.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;

  typedef enum logic [2:0] {
    RT_LATCH_WR,
    RT_LATCH_RD,
    RT_INTERNAL,
    RT_TYPE0,
    RT_TYPE1,
    RT_PLAIN_IO
  } route_e;

  typedef enum logic [1:0] {
    K_IO   = 2'd0,
    K_CFG0 = 2'd1,
    K_CFG1 = 2'd2
  } dkind_e;

  typedef struct packed {
    logic       enable;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] reg_idx;
  } cfg_sel_t;

  // Readback image of the selector register
  function automatic logic [31:0] sel_to_word(cfg_sel_t s);
    return {s.enable, 7'b0, s.bus, s.dev, s.fn, s.reg_idx, 2'b00};
  endfunction

  // Downstream configuration address image
  function automatic logic [31:0] sel_to_addr(cfg_sel_t s);
    return {8'h00, s.bus, s.dev, s.fn, s.reg_idx, 2'b00};
  endfunction

endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [22:0] load_val,
  output cfg_sel_t    sel_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (load) begin
      sel_q <= cfg_sel_t'(load_val);
    end
  end

endmodule

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
  import cfg_xlat_pkg::*;
#(
  parameter int          NUM_INT_DEV = 4,
  parameter logic [15:0] ADDR_PORT   = 16'h0CF8,
  parameter logic [15:0] DATA_PORT   = 16'h0CFC
) (
  input  logic                   enable,
  input  logic [7:0]             bus,
  input  logic [4:0]             dev,
  input  logic [13:0]            port_dw,
  input  logic [3:0]             be,
  input  logic                   write,
  input  logic [NUM_INT_DEV-2:0] dev_en,
  output route_e                 route
);

  logic [NUM_INT_DEV-1:0] int_on;
  logic                   dev_live;
  logic                   hit_addr;
  logic                   hit_data;

  // Device 0 is the host bridge and can never be turned off
  assign int_on[0] = 1'b1;
  for (genvar g = 1; g < NUM_INT_DEV; g++) begin : g_on
    assign int_on[g] = dev_en[g-1];
  end

  always_comb begin
    dev_live = 1'b0;
    for (int i = 0; i < NUM_INT_DEV; i++) begin
      if (dev == 5'(i)) dev_live = int_on[i];
    end
  end

  assign hit_addr = (port_dw == ADDR_PORT[15:2]);
  assign hit_data = (port_dw == DATA_PORT[15:2]);

  always_comb begin
    if (hit_addr && (be == 4'hF)) begin
      route = write ? RT_LATCH_WR : RT_LATCH_RD;
    end else if (hit_data && enable) begin
      if (bus != 8'h00)  route = RT_TYPE1;
      else if (dev_live) route = RT_INTERNAL;
      else               route = RT_TYPE0;
    end else begin
      route = RT_PLAIN_IO;
    end
  end

endmodule

// File: rtl/cfg_xact_seq.sv
module cfg_xact_seq
  import cfg_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hreq_valid,
  output logic        hreq_ready,
  input  logic        hreq_write,
  input  logic [15:0] hreq_port,
  input  logic [3:0]  hreq_be,
  input  logic [31:0] hreq_wdata,
  output logic        hrsp_valid,
  input  logic        hrsp_ready,
  output logic [31:0] hrsp_rdata,
  input  route_e      route,
  input  cfg_sel_t    sel,
  output logic        latch_load,
  output logic        ireg_en,
  input  logic [31:0] ireg_rdata,
  output logic        dreq_valid,
  input  logic        dreq_ready,
  output logic [1:0]  dreq_kind,
  output logic        dreq_write,
  output logic [31:0] dreq_addr,
  output logic [3:0]  dreq_be,
  output logic [31:0] dreq_wdata,
  input  logic        drsp_valid,
  output logic        drsp_ready,
  input  logic        drsp_claimed,
  input  logic [31:0] drsp_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_DREQ, S_DRSP, S_RESP} st_e;

  st_e         st_q;
  logic        accept;
  logic        fwd;
  dkind_e      kind_d;
  dkind_e      dkind_q;
  logic        dwr_q;
  logic [31:0] daddr_q;
  logic [3:0]  dbe_q;
  logic [31:0] dwd_q;
  logic [31:0] rsp_q;

  assign hreq_ready = (st_q == S_IDLE);
  assign accept     = hreq_valid && hreq_ready;
  assign latch_load = accept && (route == RT_LATCH_WR);
  assign ireg_en    = accept && (route == RT_INTERNAL);
  assign fwd        = (route == RT_TYPE0) || (route == RT_TYPE1) || (route == RT_PLAIN_IO);

  always_comb begin
    case (route)
      RT_TYPE0: kind_d = K_CFG0;
      RT_TYPE1: kind_d = K_CFG1;
      default:  kind_d = K_IO;
    endcase
  end

  assign dreq_valid = (st_q == S_DREQ);
  assign drsp_ready = (st_q == S_DRSP);
  assign hrsp_valid = (st_q == S_RESP);
  assign hrsp_rdata = rsp_q;
  assign dreq_kind  = dkind_q;
  assign dreq_write = dwr_q;
  assign dreq_addr  = daddr_q;
  assign dreq_be    = dbe_q;
  assign dreq_wdata = dwd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      rsp_q   <= '0;
      dkind_q <= K_IO;
      dwr_q   <= 1'b0;
      daddr_q <= '0;
      dbe_q   <= '0;
      dwd_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (accept) begin
            if (fwd) begin
              dkind_q <= kind_d;
              dwr_q   <= hreq_write;
              daddr_q <= (route == RT_PLAIN_IO) ? {16'h0000, hreq_port} : sel_to_addr(sel);
              dbe_q   <= hreq_be;
              dwd_q   <= hreq_wdata;
              st_q    <= S_DREQ;
            end else begin
              if (hreq_write)                 rsp_q <= '0;
              else if (route == RT_INTERNAL)  rsp_q <= ireg_rdata;
              else                            rsp_q <= sel_to_word(sel);
              st_q <= S_RESP;
            end
          end
        end
        S_DREQ: if (dreq_ready) st_q <= S_DRSP;
        S_DRSP: begin
          if (drsp_valid) begin
            rsp_q <= dwr_q ? '0 : (drsp_claimed ? drsp_rdata : '1);
            st_q  <= S_RESP;
          end
        end
        default: if (hrsp_ready) st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_access_xlat.sv
module cfg_access_xlat
  import cfg_xlat_pkg::*;
#(
  parameter int          NUM_INT_DEV = 4,
  parameter logic [15:0] ADDR_PORT   = 16'h0CF8,
  parameter logic [15:0] DATA_PORT   = 16'h0CFC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hreq_valid,
  output logic                   hreq_ready,
  input  logic                   hreq_write,
  input  logic [15:0]            hreq_port,
  input  logic [3:0]             hreq_be,
  input  logic [31:0]            hreq_wdata,
  output logic                   hrsp_valid,
  input  logic                   hrsp_ready,
  output logic [31:0]            hrsp_rdata,
  input  logic [NUM_INT_DEV-2:0] dev_en,
  output logic                   ireg_en,
  output logic                   ireg_write,
  output logic [4:0]             ireg_dev,
  output logic [2:0]             ireg_fn,
  output logic [5:0]             ireg_reg,
  output logic [3:0]             ireg_be,
  output logic [31:0]            ireg_wdata,
  input  logic [31:0]            ireg_rdata,
  output logic                   dreq_valid,
  input  logic                   dreq_ready,
  output logic [1:0]             dreq_kind,
  output logic                   dreq_write,
  output logic [31:0]            dreq_addr,
  output logic [3:0]             dreq_be,
  output logic [31:0]            dreq_wdata,
  input  logic                   drsp_valid,
  output logic                   drsp_ready,
  input  logic                   drsp_claimed,
  input  logic [31:0]            drsp_rdata
);

  cfg_sel_t sel;
  route_e   route;
  logic     latch_load;

  cfg_addr_reg u_areg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (latch_load),
    .load_val ({hreq_wdata[31], hreq_wdata[23:2]}),
    .sel_q    (sel)
  );

  cfg_route_decode #(
    .NUM_INT_DEV (NUM_INT_DEV),
    .ADDR_PORT   (ADDR_PORT),
    .DATA_PORT   (DATA_PORT)
  ) u_dec (
    .enable  (sel.enable),
    .bus     (sel.bus),
    .dev     (sel.dev),
    .port_dw (hreq_port[15:2]),
    .be      (hreq_be),
    .write   (hreq_write),
    .dev_en  (dev_en),
    .route   (route)
  );

  cfg_xact_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .hreq_valid   (hreq_valid),
    .hreq_ready   (hreq_ready),
    .hreq_write   (hreq_write),
    .hreq_port    (hreq_port),
    .hreq_be      (hreq_be),
    .hreq_wdata   (hreq_wdata),
    .hrsp_valid   (hrsp_valid),
    .hrsp_ready   (hrsp_ready),
    .hrsp_rdata   (hrsp_rdata),
    .route        (route),
    .sel          (sel),
    .latch_load   (latch_load),
    .ireg_en      (ireg_en),
    .ireg_rdata   (ireg_rdata),
    .dreq_valid   (dreq_valid),
    .dreq_ready   (dreq_ready),
    .dreq_kind    (dreq_kind),
    .dreq_write   (dreq_write),
    .dreq_addr    (dreq_addr),
    .dreq_be      (dreq_be),
    .dreq_wdata   (dreq_wdata),
    .drsp_valid   (drsp_valid),
    .drsp_ready   (drsp_ready),
    .drsp_claimed (drsp_claimed),
    .drsp_rdata   (drsp_rdata)
  );

  // Internal port carries the selector fields and the host payload
  assign ireg_write = hreq_write;
  assign ireg_dev   = sel.dev;
  assign ireg_fn    = sel.fn;
  assign ireg_reg   = sel.reg_idx;
  assign ireg_be    = hreq_be;
  assign ireg_wdata = hreq_wdata;

endmodule

// File: rtl/cfg_access_xlat_chk.sv
module cfg_access_xlat_chk
  import cfg_xlat_pkg::*;
#(
  parameter int NUM_INT_DEV = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hreq_valid,
  input logic        hreq_ready,
  input logic        hrsp_valid,
  input logic        hrsp_ready,
  input logic [31:0] hrsp_rdata,
  input logic        ireg_en,
  input logic [4:0]  ireg_dev,
  input logic        dreq_valid,
  input logic        dreq_ready,
  input logic [1:0]  dreq_kind,
  input logic        dreq_write,
  input logic [31:0] dreq_addr,
  input logic [3:0]  dreq_be,
  input logic [31:0] dreq_wdata,
  input logic        drsp_valid,
  input logic        drsp_ready
);

  assert_hold_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hrsp_valid && !hrsp_ready |=> hrsp_valid && $stable(hrsp_rdata));

  assert_hold_dreq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && !dreq_ready |=> dreq_valid && $stable(dreq_addr) && $stable(dreq_kind)
      && $stable(dreq_be) && $stable(dreq_wdata) && $stable(dreq_write));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_ready |-> !hrsp_valid && !dreq_valid && !drsp_ready);

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drsp_valid && drsp_ready |=> hrsp_valid);

  assert_internal_dev_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ireg_en |-> hreq_valid && (ireg_dev < 5'(NUM_INT_DEV)) && !dreq_valid);

  assert_type0_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && (dreq_kind == K_CFG0) |-> dreq_addr[23:16] == 8'h00);

  assert_type1_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && (dreq_kind == K_CFG1) |-> dreq_addr[23:16] != 8'h00);

  assert_cfg_layout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && (dreq_kind != K_IO) |-> dreq_addr[31:24] == 8'h00 && dreq_addr[1:0] == 2'b00);

endmodule

bind cfg_access_xlat cfg_access_xlat_chk #(.NUM_INT_DEV(NUM_INT_DEV)) u_chk (.*);

// File: tb/cfg_access_xlat_bench.sv
module cfg_access_xlat_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 2;
  localparam int NDEV       = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hreq_valid = 1'b0;
  logic        hreq_ready;
  logic        hreq_write = 1'b0;
  logic [15:0] hreq_port = '0;
  logic [3:0]  hreq_be = '0;
  logic [31:0] hreq_wdata = '0;
  logic        hrsp_valid;
  logic        hrsp_ready = 1'b0;
  logic [31:0] hrsp_rdata;
  logic [2:0]  dev_en = '0;
  logic        ireg_en, ireg_write;
  logic [4:0]  ireg_dev;
  logic [2:0]  ireg_fn;
  logic [5:0]  ireg_reg;
  logic [3:0]  ireg_be;
  logic [31:0] ireg_wdata;
  logic [31:0] ireg_rdata;
  logic        dreq_valid;
  logic        dreq_ready = 1'b0;
  logic [1:0]  dreq_kind;
  logic        dreq_write;
  logic [31:0] dreq_addr;
  logic [3:0]  dreq_be;
  logic [31:0] dreq_wdata;
  logic        drsp_valid = 1'b0;
  logic        drsp_ready;
  logic        drsp_claimed = 1'b0;
  logic [31:0] drsp_rdata = '0;

  int nchecks = 0;
  int nerr    = 0;
  int ireg_cnt = 0;
  int dreq_cnt = 0;
  int dstall   = 0;
  logic [31:0] latch_m = '0;
  logic [18:0] cap_ifields;
  logic [31:0] cap_iwd;
  logic [1:0]  cap_dkind;
  logic [31:0] cap_daddr;
  logic [4:0]  cap_dbe_wr;
  logic [31:0] cap_dwd;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench-side register file: read data derived from the presented fields
  assign ireg_rdata = {16'hC0DE, ireg_dev, ireg_fn, 2'b00, ireg_reg};

  cfg_access_xlat #(.NUM_INT_DEV(NDEV)) u_cfg_access_xlat (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit claims(logic [1:0] kind, logic [31:0] addr);
    if (kind == 2'd0) return addr[15:0] != 16'h0080;
    return (addr[23:16] != 8'hFF) && !((kind == 2'd1) && (addr[15:11] == 5'd31));
  endfunction

  // 0 latch, 1 internal, 2 type0, 3 type1, 4 plain io
  function automatic int exp_route(logic [15:0] port, logic [3:0] be);
    logic [4:0] d;
    if (port[15:2] == 14'h033E && be == 4'hF) return 0;
    if (port[15:2] == 14'h033F && latch_m[31]) begin
      if (latch_m[23:16] != 8'h00) return 3;
      d = latch_m[15:11];
      if (d == 5'd0) return 1;
      if (d < 5'(NDEV) && dev_en[d-1]) return 1;
      return 2;
    end
    return 4;
  endfunction

  // Per-clock monitor
  initial begin
    forever begin
      @(negedge clk); #Q;
      if (rst_n) begin
        chk("R10 no response while idle", {63'b0, hrsp_valid && hreq_ready}, 64'd0);
        if (ireg_en) begin
          ireg_cnt++;
          cap_ifields = {ireg_dev, ireg_fn, ireg_reg, ireg_be, ireg_write};
          cap_iwd     = ireg_wdata;
        end
      end
    end
  end

  // Downstream responder
  initial begin
    bit r;
    forever begin
      @(negedge clk); #Q;
      if (rst_n && dreq_valid) begin
        for (int k = 0; k < dstall; k++) begin @(negedge clk); #Q; end
        cap_dkind  = dreq_kind;
        cap_daddr  = dreq_addr;
        cap_dbe_wr = {dreq_be, dreq_write};
        cap_dwd    = dreq_wdata;
        dreq_ready = 1'b1;
        @(posedge clk);
        dreq_cnt++;
        @(negedge clk);
        dreq_ready = 1'b0;
        for (int k = 0; k < dstall; k++) @(negedge clk);
        drsp_valid   = 1'b1;
        drsp_claimed = claims(cap_dkind, cap_daddr);
        drsp_rdata   = cap_daddr ^ 32'h5A5A_0000;
        forever begin
          #Q; r = drsp_ready;
          @(posedge clk);
          if (r) break;
          @(negedge clk);
        end
        @(negedge clk);
        drsp_valid = 1'b0;
      end
    end
  end

  task automatic run(string tag, logic wr, logic [15:0] port, logic [3:0] be,
                     logic [31:0] wd, int hstall, int ds);
    int rt, i0, d0, cyc;
    bit rdy;
    logic [31:0] got, exp, eaddr;
    logic [1:0] ekind;
    rt = exp_route(port, be);
    i0 = ireg_cnt; d0 = dreq_cnt; dstall = ds;
    ekind = (rt == 2) ? 2'd1 : (rt == 3) ? 2'd2 : 2'd0;
    eaddr = (rt == 4) ? {16'h0000, port} : (latch_m & 32'h00FF_FFFC);
    if (wr)           exp = '0;
    else if (rt == 0) exp = latch_m;
    else if (rt == 1) exp = {16'hC0DE, latch_m[15:11], latch_m[10:8], 2'b00, latch_m[7:2]};
    else              exp = claims(ekind, eaddr) ? (eaddr ^ 32'h5A5A_0000) : 32'hFFFF_FFFF;
    @(negedge clk);
    hreq_valid = 1'b1; hreq_write = wr; hreq_port = port; hreq_be = be; hreq_wdata = wd;
    forever begin
      #Q; rdy = hreq_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    hreq_valid = 1'b0;
    cyc = 0;
    forever begin
      hrsp_ready = (cyc >= hstall);
      #Q;
      if (hrsp_valid && hrsp_ready) begin got = hrsp_rdata; @(posedge clk); break; end
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
    hrsp_ready = 1'b0;
    chk({tag, " internal strobes"}, 64'(ireg_cnt - i0), (rt == 1) ? 64'd1 : 64'd0);
    chk({tag, " downstream requests"}, 64'(dreq_cnt - d0), (rt >= 2) ? 64'd1 : 64'd0);
    if (rt == 1) begin
      chk({tag, " internal fields"}, 64'(cap_ifields), 64'({latch_m[15:11], latch_m[10:8], latch_m[7:2], be, wr}));
      chk({tag, " internal wdata"}, 64'(cap_iwd), 64'(wd));
    end
    if (rt >= 2) begin
      chk({tag, " kind"}, 64'(cap_dkind), 64'(ekind));
      chk({tag, " address"}, 64'(cap_daddr), 64'(eaddr));
      chk({tag, " enables"}, 64'(cap_dbe_wr), 64'({be, wr}));
      chk({tag, " wdata"}, 64'(cap_dwd), 64'(wd));
    end
    chk({tag, " response"}, 64'(got), 64'(exp));
    if (rt == 0 && wr) latch_m = wd & 32'h80FF_FFFC;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R10 watchdog expired act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #Q;
    chk("R2 reset handshake state", {60'b0, hreq_ready, hrsp_valid, dreq_valid, ireg_en}, 64'h8);
    run("R2 selector zero after reset", 0, 16'h0CF8, 4'hF, 0, 0, 0);
    run("R1 load all ones", 1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF, 1, 0);
    run("R1 masked readback", 0, 16'h0CF8, 4'hF, 0, 2, 0);
    run("R3 byte write to address port", 1, 16'h0CF8, 4'b0001, 32'h0000_0012, 0, 1);
    run("R3 selector unchanged", 0, 16'h0CF8, 4'hF, 0, 0, 0);
    run("R1 load with enable clear", 1, 16'h0CF8, 4'hF, 32'h0001_0804, 0, 0);
    run("R3 window while disabled", 0, 16'h0CFC, 4'hF, 0, 1, 2);
    dev_en = 3'b000;
    run("R1 select host bridge", 1, 16'h0CF8, 4'hF, 32'h8000_0114, 0, 0);
    run("R5 host bridge internal", 0, 16'h0CFC, 4'hF, 0, 3, 0);
    dev_en = 3'b010;
    run("R1 select device 2", 1, 16'h0CF8, 4'hF, 32'h8000_100C, 0, 0);
    run("R4 R8 enabled device partial write", 1, 16'h0CFC, 4'b0110, 32'hDEAD_BEEF, 1, 0);
    run("R4 enabled device read", 0, 16'h0CFC, 4'hF, 0, 0, 0);
    dev_en = 3'b101;
    run("R6 disabled device goes type0", 0, 16'h0CFC, 4'b0011, 0, 0, 2);
    run("R1 select device 7", 1, 16'h0CF8, 4'hF, 32'h8000_3800, 0, 0);
    run("R6 external bus0 device type0", 1, 16'h0CFC, 4'hF, 32'h1234_5678, 2, 1);
    run("R1 select device 31", 1, 16'h0CF8, 4'hF, 32'h8000_F800, 0, 0);
    run("R9 absent device reads ones", 0, 16'h0CFC, 4'hF, 0, 0, 0);
    run("R1 select bus 3", 1, 16'h0CF8, 4'hF, 32'h8003_2A24, 0, 0);
    run("R7 R8 type1 upper half read", 0, 16'h0CFC, 4'b1100, 0, 2, 3);
    run("R7 R8 type1 byte write", 1, 16'h0CFC, 4'b0001, 32'h0000_00A5, 0, 0);
    run("R1 select bus 255", 1, 16'h0CF8, 4'hF, 32'h80FF_0000, 0, 0);
    run("R9 unclaimed type1 reads ones", 0, 16'h0CFC, 4'hF, 0, 1, 1);
    run("R9 unclaimed plain io reads ones", 0, 16'h0080, 4'hF, 0, 0, 0);
    run("R3 plain io write", 1, 16'h0060, 4'b0001, 32'h0000_0077, 0, 2);
    run("R3 plain io read", 0, 16'h0064, 4'hF, 0, 2, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

endmodule